// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block supplies the column address for every data beat of an SDRAM read or write burst. When the controller accepts a READ or WRITE it pulses a start strobe together with the starting column, a burst-length code and an ordering select. From the next cycle on, the block presents one column per clock. It walks the locations of the burst in linear-wrap or XOR (interleaved) order and marks the final beat. The controller may cut a burst short with a stop strobe, which stands for a burst-stop or precharge command. It may also begin a fresh burst on any cycle.

Length codes select 1, 2, 4 or 8 beats, or a full-page run. A full-page run steps through the whole row, wraps at the row end and continues until it is stopped. The length, the ordering and the start column are captured when a burst begins. Changes on those inputs during a burst are ignored. The row width is a parameter, 9 bits (512 columns) by default. A second parameter removes the XOR ordering path.

Top module: `burst_colgen`

## Requirements
- R1: While reset is asserted and afterwards with no start, `valid_o` and `last_o` are low.
- R2: A cycle with `start_i` high yields, in the next cycle, `valid_o` high and `col_o` equal to that cycle's `start_col_i`. This holds even when a burst is already running, which is then abandoned.
- R3: `len_code_i` 0, 1, 2, 3 give bursts of 1, 2, 4 and 8 beats, with `valid_o` high for exactly that many consecutive cycles. Codes 4, 5 and 6 behave as length 1.
- R4: With `interleave_i` low and a fixed length L, beat k has low log2(L) bits equal to (start low bits + k) mod L. The upper bits equal those of the start column.
- R5: With `interleave_i` high and a fixed length L, beat k has low log2(L) bits equal to start low bits XOR k. The upper bits are unchanged.
- R6: `len_code_i` 7 is full page. Beat k is (start + k) mod 2^COL_W, so it wraps from the top column to 0. The run continues until stopped, and `interleave_i` has no effect.
- R7: `last_o` is high only on the final beat of a fixed-length burst and never during a full-page run.
- R8: `stop_i` high (without `start_i`) during a burst makes `valid_o` low in the next cycle. When `start_i` and `stop_i` are high together, the start wins.
- R9: Changes on `len_code_i` and `interleave_i` after the start cycle do not alter the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst at `start_col_i` |
| stop_i | input | 1 | Terminate the running burst |
| start_col_i | input | COL_W | Starting column |
| len_code_i | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 7:full page) |
| interleave_i | input | 1 | 1 selects XOR ordering, 0 linear wrap |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final beat of a fixed burst |

## Verification
Every output is one register stage behind its cause. The first beat shows in the cycle after the start edge, and each later beat one cycle after the previous one. A stop or the final beat clears `valid_o` one cycle after the edge that sampled it. The driver changes inputs on the falling edge and records the expected output for the next rising edge. The monitor compares it one time unit after that rising edge, so every comparison lands in the exact cycle the result is due. Each queued item holds the full expected output state for its cycle, so an early or late beat shows up as a mismatch and is reported.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;

   localparam int LEN_CODE_W = 3;

   localparam logic [LEN_CODE_W-1:0] LEN_ONE  = 3'd0;
   localparam logic [LEN_CODE_W-1:0] LEN_TWO  = 3'd1;
   localparam logic [LEN_CODE_W-1:0] LEN_FOUR = 3'd2;
   localparam logic [LEN_CODE_W-1:0] LEN_EIGHT = 3'd3;
   localparam logic [LEN_CODE_W-1:0] LEN_PAGE = 3'd7;

   typedef enum logic [1:0] {
      ORD_WRAP   = 2'd0,
      ORD_XOR    = 2'd1,
      ORD_LINEAR = 2'd2
   } order_e;

endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode
   import burst_colgen_pkg::*;
#(
   parameter int COL_W   = 9,
   parameter bit HAS_XOR = 1'b1
) (
   input  logic [LEN_CODE_W-1:0] code_i,
   input  logic                  xor_req_i,
   output logic [COL_W-1:0]      mask_o,
   output logic                  page_o,
   output order_e                order_o
);

   logic xor_ok;

   generate
      if (HAS_XOR) begin : g_xor_en
         assign xor_ok = xor_req_i;
      end else begin : g_xor_dis
         assign xor_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      mask_o = '0;
      page_o = 1'b0;
      unique case (code_i)
         LEN_TWO:   mask_o = COL_W'(1);
         LEN_FOUR:  mask_o = COL_W'(3);
         LEN_EIGHT: mask_o = COL_W'(7);
         LEN_PAGE: begin
            mask_o = '1;
            page_o = 1'b1;
         end
         default:   mask_o = '0;
      endcase
      if (page_o)      order_o = ORD_LINEAR;
      else if (xor_ok) order_o = ORD_XOR;
      else             order_o = ORD_WRAP;
   end

endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr #(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             page_i,
   output logic [COL_W-1:0] beat_o,
   output logic             active_o,
   output logic             final_o
);

   assign final_o = active_o && !page_i && (beat_o == mask_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_o <= 1'b0;
         beat_o   <= '0;
      end else if (start_i) begin
         active_o <= 1'b1;
         beat_o   <= '0;
      end else if (active_o) begin
         if (stop_i || final_o) begin
            active_o <= 1'b0;
            beat_o   <= '0;
         end else begin
            beat_o <= beat_o + COL_W'(1);
         end
      end
   end

endmodule

// File: rtl/colgen_addr_calc.sv
module colgen_addr_calc
   import burst_colgen_pkg::*;
#(
   parameter int COL_W   = 9,
   parameter bit HAS_XOR = 1'b1
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] mask_i,
   input  order_e           order_i,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] sum;
   logic [COL_W-1:0] hold_bits;
   logic [COL_W-1:0] xor_low;

   assign sum       = base_i + beat_i;
   assign hold_bits = base_i & ~mask_i;

   generate
      if (HAS_XOR) begin : g_xor
         assign xor_low = (base_i ^ beat_i) & mask_i;
      end else begin : g_no_xor
         assign xor_low = sum & mask_i;
      end
   endgenerate

   always_comb begin
      unique case (order_i)
         ORD_LINEAR: col_o = sum;
         ORD_XOR:    col_o = hold_bits | xor_low;
         default:    col_o = hold_bits | (sum & mask_i);
      endcase
   end

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
   import burst_colgen_pkg::*;
#(
   parameter int COL_W   = 9,
   parameter bit HAS_XOR = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic                  stop_i,
   input  logic [COL_W-1:0]      start_col_i,
   input  logic [LEN_CODE_W-1:0] len_code_i,
   input  logic                  interleave_i,
   output logic [COL_W-1:0]      col_o,
   output logic                  valid_o,
   output logic                  last_o
);

   localparam int MAX_FIXED = 8;

   generate
      if (COL_W < $clog2(MAX_FIXED)) begin : g_bad_width
         $error("burst_colgen: COL_W too small for an 8-beat burst");
      end
   endgenerate

   logic [COL_W-1:0] dec_mask;
   logic             dec_page;
   order_e           dec_order;

   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] mask_q;
   logic             page_q;
   order_e           order_q;

   logic [COL_W-1:0] beat;
   logic             active;
   logic             final_beat;

   colgen_len_decode #(.COL_W(COL_W), .HAS_XOR(HAS_XOR)) u_dec (
      .code_i    (len_code_i),
      .xor_req_i (interleave_i),
      .mask_o    (dec_mask),
      .page_o    (dec_page),
      .order_o   (dec_order)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         mask_q  <= '0;
         page_q  <= 1'b0;
         order_q <= ORD_WRAP;
      end else if (start_i) begin
         base_q  <= start_col_i;
         mask_q  <= dec_mask;
         page_q  <= dec_page;
         order_q <= dec_order;
      end
   end

   colgen_beat_ctr #(.COL_W(COL_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .stop_i   (stop_i),
      .mask_i   (mask_q),
      .page_i   (page_q),
      .beat_o   (beat),
      .active_o (active),
      .final_o  (final_beat)
   );

   colgen_addr_calc #(.COL_W(COL_W), .HAS_XOR(HAS_XOR)) u_addr (
      .base_i  (base_q),
      .beat_i  (beat),
      .mask_i  (mask_q),
      .order_i (order_q),
      .col_o   (col_o)
   );

   assign valid_o = active;
   assign last_o  = final_beat;

endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
   parameter int COL_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             stop_i,
   input logic [COL_W-1:0] start_col_i,
   input logic [2:0]       len_code_i,
   input logic [COL_W-1:0] col_o,
   input logic             valid_o,
   input logic             last_o
);

   p_start_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (valid_o && col_o == $past(start_col_i)));

   p_single_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && len_code_i == 3'd0) |=> last_o);

   p_last_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !valid_o);

   p_page_no_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && len_code_i == 3'd7) |=> !last_o);

   p_last_in_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i) |=> !valid_o);

endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .stop_i      (stop_i),
   .start_col_i (start_col_i),
   .len_code_i  (len_code_i),
   .col_o       (col_o),
   .valid_o     (valid_o),
   .last_o      (last_o)
);

// File: tb/burst_colgen_bench.sv
module burst_colgen_bench;

   localparam int COL_W = 9;

   typedef struct {
      logic             valid;
      logic [COL_W-1:0] col;
      logic             last;
      string            tag;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic             stop_i = 1'b0;
   logic [COL_W-1:0] start_col_i = '0;
   logic [2:0]       len_code_i = 3'd0;
   logic             interleave_i = 1'b0;
   logic [COL_W-1:0] col_o;
   logic             valid_o;
   logic             last_o;

   int   checks = 0;
   int   errors = 0;
   bit   mon_en = 1'b0;
   bit   done = 1'b0;
   exp_t sb[$];

   always #5 clk = ~clk;

   burst_colgen #(.COL_W(COL_W)) u_burst_colgen (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .start_col_i(start_col_i), .len_code_i(len_code_i),
      .interleave_i(interleave_i), .col_o(col_o), .valid_o(valid_o),
      .last_o(last_o)
   );

   function automatic int blen(input logic [2:0] code);
      case (code)
         3'd1: return 2;
         3'd2: return 4;
         3'd3: return 8;
         default: return 1;
      endcase
   endfunction

   function automatic logic [COL_W-1:0] ecol(input logic [COL_W-1:0] base,
                                             input logic [2:0] code,
                                             input logic ilv, input int k);
      logic [COL_W-1:0] m;
      logic [COL_W-1:0] kk;
      kk = COL_W'(k);
      if (code == 3'd7) return base + kk;
      m = COL_W'(blen(code) - 1);
      if (ilv) return (base & ~m) | ((base ^ kk) & m);
      return (base & ~m) | ((base + kk) & m);
   endfunction

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
   endtask

   // one driven cycle; expectation is for the output after the next rising edge
   task automatic step(input logic st, input logic sp, input logic [COL_W-1:0] c,
                       input logic [2:0] code, input logic ilv,
                       input logic ev, input logic [COL_W-1:0] ec,
                       input logic el, input string tag);
      exp_t e;
      @(negedge clk);
      start_i = st; stop_i = sp; start_col_i = c;
      len_code_i = code; interleave_i = ilv;
      e.valid = ev; e.col = ec; e.last = el; e.tag = tag;
      sb.push_back(e);
      mon_en = 1'b1;
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++)
         step(1'b0, 1'b0, 9'h0AA, 3'd2, 1'b1, 1'b0, '0, 1'b0, tag);
   endtask

   // stop_at: beat index whose cycle carries stop (-1 none); cut_at: return
   // before that beat without idling (-1 none); stop_too: stop with start
   task automatic burst(input logic [COL_W-1:0] base, input logic [2:0] code,
                        input logic ilv, input int stop_at, input int cut_at,
                        input bit stop_too, input string tag);
      int  len;
      bit  page;
      page = (code == 3'd7);
      len  = blen(code);
      step(1'b1, stop_too, base, code, ilv, 1'b1, ecol(base, code, ilv, 0),
           !page && len == 1, tag);
      for (int k = 1; ; k++) begin
         if (k == cut_at) return;
         // R9: config inputs disturbed during the burst
         if (k == stop_at) begin
            step(1'b0, 1'b1, ~base, code ^ 3'd2, ~ilv, 1'b0, '0, 1'b0, tag);
            return;
         end
         if (!page && k >= len) begin
            step(1'b0, 1'b0, ~base, code ^ 3'd2, ~ilv, 1'b0, '0, 1'b0, tag);
            return;
         end
         step(1'b0, 1'b0, ~base, code ^ 3'd2, ~ilv, 1'b1,
              ecol(base, code, ilv, k), !page && k == len - 1, tag);
      end
   endtask

   // scoreboard monitor
   always @(posedge clk) begin
      #1;
      if (mon_en && sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (valid_o !== e.valid || last_o !== e.last ||
             (e.valid && col_o !== e.col)) begin
            errors++;
            $display("FAIL %s: actual v=%0b col=%h last=%0b expected v=%0b col=%h last=%0b",
                     e.tag, valid_o, col_o, last_o, e.valid, e.col, e.last);
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      start_i = 1'b1; len_code_i = 3'd3;
      repeat (3) @(negedge clk);
      check("R1 valid in reset", valid_o, 1'b0);
      check("R1 last in reset", last_o, 1'b0);
      start_i = 1'b0;
      rst_n = 1'b1;
      idle(2, "R1 idle after reset");
      burst(9'h005, 3'd0, 1'b0, -1, -1, 1'b0, "R3 len1");
      burst(9'h009, 3'd5, 1'b0, -1, -1, 1'b0, "R3 reserved code as len1");
      burst(9'h00D, 3'd1, 1'b0, -1, -1, 1'b0, "R4 wrap len2");
      burst(9'h00D, 3'd2, 1'b0, -1, -1, 1'b0, "R4 wrap len4");
      burst(9'h1FE, 3'd3, 1'b0, -1, -1, 1'b0, "R4 wrap len8 R9");
      burst(9'h003, 3'd1, 1'b1, -1, -1, 1'b0, "R5 xor len2");
      burst(9'h006, 3'd2, 1'b1, -1, -1, 1'b0, "R5 xor len4");
      burst(9'h00B, 3'd3, 1'b1, -1, -1, 1'b0, "R5 xor len8 R9");
      burst(9'h1FC, 3'd7, 1'b1, 10, -1, 1'b0, "R6 page wrap R7");
      burst(9'h120, 3'd7, 1'b0, 3, -1, 1'b0, "R6 page short");
      burst(9'h015, 3'd3, 1'b0, 3, -1, 1'b0, "R8 stop len8");
      burst(9'h028, 3'd3, 1'b0, -1, 2, 1'b0, "R2 restart cut");
      burst(9'h064, 3'd2, 1'b1, -1, -1, 1'b0, "R2 restart new");
      burst(9'h007, 3'd3, 1'b0, -1, -1, 1'b1, "R8 start beats stop");
      step(1'b0, 1'b1, '0, 3'd0, 1'b0, 1'b0, '0, 1'b0, "R8 stop while idle");
      idle(2, "R1 idle end");
      @(posedge clk);
      #3;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule